// File: doc/BRIEF.md
# Staged Boot Sequencer

This block is the control state machine of a peripheral that comes up in three stages: a first-level boot loader (stage 0), a second-level boot loader (stage 1) and the application. A host changes stage or erases flash banks by writing a 16-bit command word. It also writes a 16-bit feature-enable mask. The block tracks four things: the current stage, a fault code, a bank-ready mask and three sticky bank-erased flags. It serves the matching read values on a combinational read port.

Image verification results, the write-protect state and flash ECC errors arrive from outside as flags. The ECC error is latched inside the block and consumed by the launch attempt that reports it. Flash contents, signature checking and the bus decoder stay outside the block. The host register decoder drives `cmd_we`, `feat_we` and `rd_sel` directly.

Top module: `boot_stage_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in stage 0 (`stage` = 0; stage encoding 0 = stage 0, 1 = stage 1, 2 = application). The fault code is 0, the feature mask is 0, the bank-ready mask is 3'b001, every `bank_erased` bit is 0 and the latched ECC flag is clear.
- R2: A command word uses bit 0 = reset, bit 1 = launch stage 1, bit 2 = launch application, bit 3 = erase stage-1 flash and bit 4 = erase external flash. Only the lowest-numbered set bit is considered. If that command is not legal in the current stage, the whole write has no effect.
- R3: Launch stage 1 acts only in stage 0. If `s1_unverified` is high and `wp_off` is low, the fault code becomes 1 (invalid signature). Otherwise, if the latched ECC flag is set, the fault code becomes 2 (flash ECC) and the flag clears. Otherwise the block enters stage 1.
- R4: Launch application acts only in stage 1. It sets the fault code to 3 (not verified) when `ext_unverified` is high, and otherwise enters the application stage. The application stage is never entered directly from stage 0.
- R5: Launch commands issued outside their legal stage change neither the stage nor the fault code.
- R6: The `bank_erased` bits are 0 = stage-1 flash, 1 = external flash and 2 = SoC ROM. Erase stage-1 flash sets bit 0 and acts only in stage 0. Erase external flash sets bits 1 and 2 and acts only in stage 1. No command clears these bits.
- R7: The reset command enters stage 0 from any stage. It clears the fault code and the feature mask and leaves `bank_erased` unchanged. It wins over a feature write in the same cycle.
- R8: The bank-ready mask (read select 1) is 3'b001 in stage 0, 3'b110 in stage 1 and 0 in the application stage.
- R9: The status word (read select 0) is built as follows. Bit 0 is always 1. Bit 1 is set when the fault code is nonzero. Bits 2, 3 and 4 flag stage 0, stage 1 and application respectively. Bit 5 is set when `wp_off` is high, and bit 6 is set when `wp_off` is low. All other bits are 0.
- R10: The hardware revision (read select 3) reads 0x0104 in stage 0 and 0 otherwise. The firmware version high half (select 4) and low half (select 5) return `fw_version[31:16]` and `fw_version[15:0]` in stage 1 and 0xFFFF in other stages. The fault code reads zero-extended on select 2.
- R11: A feature write stores `wr_data` as the feature mask. Feature result 0 (select 6) and feature result 1 (select 7) return `feat0_result` and `feat1_result` when mask bit 0 or bit 1 respectively is set, and 0 otherwise.
- R12: A pulse on `ecc_err_set` latches the ECC flag until a launch stage 1 attempt consumes it. A second launch after the consuming one succeeds if nothing else blocks it.
- R13: Read selects 8 to 15 return 0. Without a command write, the stage and the fault code hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| feat_we | input | 1 | Write strobe for the feature mask |
| wr_data | input | 16 | Write data |
| s1_unverified | input | 1 | Stage-1 image failed verification |
| wp_off | input | 1 | Write protect is disabled |
| ext_unverified | input | 1 | External flash image failed verification |
| ecc_err_set | input | 1 | Pulse: stage-1 flash ECC error seen |
| fw_version | input | 32 | Stored firmware version |
| feat0_result | input | 16 | Feature 0 result value |
| feat1_result | input | 16 | Feature 1 result value |
| rd_sel | input | 4 | Read select |
| rd_data | output | 16 | Read data for `rd_sel` |
| stage | output | 2 | Current stage |
| bank_erased | output | 3 | Sticky bank-erased flags |

## Verification
The assertions check several rules on every cycle. The bank-ready mask must agree with the stage. Stage and fault code must hold without a command write. Erased flags must never clear. The application stage must never follow stage 0 directly. The status OK bit must be set, and the stage bits of the status word must be one-hot. Only the bench's scenarios can show that the command priority is obeyed and that each failed launch records its own fault code. The same holds for consuming the latched ECC flag, for the stage-gated register values, and for the reset command sparing the erased flags.

// File: rtl/boot_stage_ctrl.sv
module boot_stage_ctrl #(
  parameter logic [15:0] HW_REV_ID = 16'h0104
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        feat_we,
  input  logic [15:0] wr_data,
  input  logic        s1_unverified,
  input  logic        wp_off,
  input  logic        ext_unverified,
  input  logic        ecc_err_set,
  input  logic [31:0] fw_version,
  input  logic [15:0] feat0_result,
  input  logic [15:0] feat1_result,
  input  logic [3:0]  rd_sel,
  output logic [15:0] rd_data,
  output logic [1:0]  stage,
  output logic [2:0]  bank_erased
);

  localparam logic [1:0] ST_S0  = 2'd0;
  localparam logic [1:0] ST_S1  = 2'd1;
  localparam logic [1:0] ST_APP = 2'd2;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_SIG  = 2'd1;
  localparam logic [1:0] FLT_ECC  = 2'd2;
  localparam logic [1:0] FLT_NVER = 2'd3;

  logic [1:0]  stage_q;
  logic [1:0]  fault_q;
  logic [15:0] feat_q;
  logic [2:0]  ready_q;
  logic [2:0]  erased_q;
  logic        ecc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= ST_S0;
      fault_q  <= FLT_NONE;
      feat_q   <= '0;
      ready_q  <= 3'b001;
      erased_q <= '0;
      ecc_q    <= 1'b0;
    end else begin
      ecc_q <= ecc_q | ecc_err_set;
      if (feat_we) feat_q <= wr_data;
      if (cmd_we) begin
        if (wr_data[0]) begin
          stage_q <= ST_S0;
          ready_q <= 3'b001;
          fault_q <= FLT_NONE;
          feat_q  <= '0;
        end else if (wr_data[1]) begin
          if (stage_q == ST_S0) begin
            if (s1_unverified && !wp_off) begin
              fault_q <= FLT_SIG;
            end else if (ecc_q) begin
              fault_q <= FLT_ECC;
              ecc_q   <= ecc_err_set;
            end else begin
              stage_q <= ST_S1;
              ready_q <= 3'b110;
            end
          end
        end else if (wr_data[2]) begin
          if (stage_q == ST_S1) begin
            if (ext_unverified) begin
              fault_q <= FLT_NVER;
            end else begin
              stage_q <= ST_APP;
              ready_q <= 3'b000;
            end
          end
        end else if (wr_data[3]) begin
          if (stage_q == ST_S0) erased_q[0] <= 1'b1;
        end else if (wr_data[4]) begin
          if (stage_q == ST_S1) erased_q[2:1] <= 2'b11;
        end
      end
    end
  end

  logic [15:0] status_w;
  assign status_w = {9'd0, !wp_off, wp_off, stage_q == ST_APP, stage_q == ST_S1,
                     stage_q == ST_S0, fault_q != FLT_NONE, 1'b1};

  always_comb begin
    case (rd_sel)
      4'd0:    rd_data = status_w;
      4'd1:    rd_data = {13'd0, ready_q};
      4'd2:    rd_data = {14'd0, fault_q};
      4'd3:    rd_data = (stage_q == ST_S0) ? HW_REV_ID : 16'h0000;
      4'd4:    rd_data = (stage_q == ST_S1) ? fw_version[31:16] : 16'hFFFF;
      4'd5:    rd_data = (stage_q == ST_S1) ? fw_version[15:0] : 16'hFFFF;
      4'd6:    rd_data = feat_q[0] ? feat0_result : 16'h0000;
      4'd7:    rd_data = feat_q[1] ? feat1_result : 16'h0000;
      default: rd_data = 16'h0000;
    endcase
  end

  assign stage       = stage_q;
  assign bank_erased = erased_q;

  // R8
  ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q == ((stage_q == ST_S0) ? 3'b001 : (stage_q == ST_S1) ? 3'b110 : 3'b000));

  // R13
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(stage_q));

  // R13
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(fault_q));

  // R6
  erased_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((erased_q & $past(erased_q)) == $past(erased_q)));

  // R4
  no_skip_app_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_S0) |=> (stage_q != ST_APP));

  // R9
  status_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 4'd0) |-> (rd_data[0] && $onehot(rd_data[4:2]) && (rd_data[5] != rd_data[6])));

endmodule

// File: tb/boot_stage_ctrl_bench.sv
module boot_stage_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic        feat_we = 1'b0;
  logic [15:0] wr_data = '0;
  logic        s1_unverified = 1'b0;
  logic        wp_off = 1'b0;
  logic        ext_unverified = 1'b0;
  logic        ecc_err_set = 1'b0;
  logic [31:0] fw_version = 32'h1234_5678;
  logic [15:0] feat0_result = 16'hAAAA;
  logic [15:0] feat1_result = 16'h5555;
  logic [3:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic [1:0]  stage;
  logic [2:0]  bank_erased;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_stage_ctrl u_boot_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .feat_we(feat_we), .wr_data(wr_data),
    .s1_unverified(s1_unverified), .wp_off(wp_off), .ext_unverified(ext_unverified),
    .ecc_err_set(ecc_err_set), .fw_version(fw_version), .feat0_result(feat0_result),
    .feat1_result(feat1_result), .rd_sel(rd_sel), .rd_data(rd_data), .stage(stage),
    .bank_erased(bank_erased)
  );

  // {op(2): 0 none / 1 command / 2 feature, data(16), rd_sel(4), expected(16)}
  localparam int NV = 19;
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 16'h0000, 4'd0, 16'h0045},  // R9 reset status
    {2'd0, 16'h0000, 4'd3, 16'h0104},  // R10
    {2'd0, 16'h0000, 4'd4, 16'hFFFF},  // R10
    {2'd2, 16'h0001, 4'd6, 16'hAAAA},  // R11
    {2'd0, 16'h0000, 4'd7, 16'h0000},  // R11
    {2'd1, 16'h0004, 4'd0, 16'h0045},  // R5 launch app in stage 0
    {2'd1, 16'h0008, 4'd1, 16'h0001},  // R8
    {2'd1, 16'h0002, 4'd0, 16'h0049},  // R3 enter stage 1
    {2'd0, 16'h0000, 4'd1, 16'h0006},  // R8
    {2'd0, 16'h0000, 4'd4, 16'h1234},  // R10
    {2'd0, 16'h0000, 4'd5, 16'h5678},  // R10
    {2'd0, 16'h0000, 4'd3, 16'h0000},  // R10
    {2'd0, 16'h0000, 4'd6, 16'hAAAA},  // R11
    {2'd1, 16'h0004, 4'd0, 16'h0051},  // R4 enter app
    {2'd0, 16'h0000, 4'd1, 16'h0000},  // R8
    {2'd0, 16'h0000, 4'd4, 16'hFFFF},  // R10
    {2'd1, 16'h0001, 4'd0, 16'h0045},  // R7
    {2'd0, 16'h0000, 4'd6, 16'h0000},  // R7 mask cleared
    {2'd0, 16'h0000, 4'd9, 16'h0000}   // R13
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    wr_data = d;
    cmd_we  = (op == 2'd1);
    feat_we = (op == 2'd2);
    @(negedge clk);
    cmd_we  = 1'b0;
    feat_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] sel, input logic [15:0] exp);
    rd_sel = sel;
    #1;
    chk(tag, {16'd0, rd_data}, {16'd0, exp});
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stage", {30'd0, stage}, 32'd0);
    chk("R1 erased", {29'd0, bank_erased}, 32'd0);
    rd("R1 fault", 4'd2, 16'h0000);
    rd("R1 ready", 4'd1, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37:36] != 2'd0) wr(VEC[i][37:36], VEC[i][35:20]);
      rd($sformatf("table R2-vector %0d", i), VEC[i][19:16], VEC[i][15:0]);
    end

    // R6 erase external ignored in stage 0
    wr(2'd1, 16'h0010);
    chk("R6 erase ext in stage 0", {29'd0, bank_erased}, 32'd1);

    // R3 invalid signature
    s1_unverified = 1'b1;
    wr(2'd1, 16'h0002);
    rd("R3 sig fault", 4'd2, 16'h0001);
    rd("R3 status with fault", 4'd0, 16'h0047);
    chk("R3 stays stage 0", {30'd0, stage}, 32'd0);

    // R2 launch beats erase; write protect off allows unverified stage 1
    wp_off = 1'b1;
    rd("R9 wp off status", 4'd0, 16'h0027);
    wr(2'd1, 16'h000A);
    chk("R2 launch wins", {30'd0, stage}, 32'd1);
    chk("R2 erase skipped", {29'd0, bank_erased}, 32'd1);
    rd("R13 fault kept", 4'd2, 16'h0001);

    // R2 illegal top command blocks lower erase
    wr(2'd1, 16'h0012);
    chk("R2 blocked erase", {29'd0, bank_erased}, 32'd1);
    chk("R5 launch1 in stage 1", {30'd0, stage}, 32'd1);

    // R4 not verified
    ext_unverified = 1'b1;
    wr(2'd1, 16'h0004);
    rd("R4 nver fault", 4'd2, 16'h0003);
    chk("R4 stays stage 1", {30'd0, stage}, 32'd1);

    // R6 erase external in stage 1
    wr(2'd1, 16'h0010);
    chk("R6 erase ext", {29'd0, bank_erased}, 32'd7);

    // R7 reset command beats feature write, keeps erased flags
    s1_unverified = 1'b0;
    wp_off = 1'b0;
    ext_unverified = 1'b0;
    @(negedge clk);
    wr_data = 16'h0001;
    cmd_we = 1'b1;
    feat_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    feat_we = 1'b0;
    chk("R7 stage", {30'd0, stage}, 32'd0);
    chk("R7 erased kept", {29'd0, bank_erased}, 32'd7);
    rd("R7 fault cleared", 4'd2, 16'h0000);
    rd("R7 feature mask cleared", 4'd6, 16'h0000);

    // R12 latched ECC flag
    @(negedge clk);
    ecc_err_set = 1'b1;
    @(negedge clk);
    ecc_err_set = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd1, 16'h0002);
    rd("R12 ecc fault", 4'd2, 16'h0002);
    chk("R12 stays stage 0", {30'd0, stage}, 32'd0);
    wr(2'd1, 16'h0002);
    chk("R12 flag consumed", {30'd0, stage}, 32'd1);
    rd("R12 fault kept", 4'd2, 16'h0002);

    // R11 both features in stage 1
    wr(2'd2, 16'h0003);
    rd("R11 feature 1", 4'd7, 16'h5555);
    rd("R11 feature 0", 4'd6, 16'hAAAA);

    // R13 hold without writes
    repeat (5) @(negedge clk);
    chk("R13 stage hold", {30'd0, stage}, 32'd1);
    rd("R13 unmapped", 4'd15, 16'h0000);

    finish_run();
  end

endmodule